// File: doc/BRIEF.md
# GPS Code Phase Accumulator

This block holds the code phase of one receiver tracking channel as a running time count. The count has three linked fields. A fractional-chip field sits at the bottom. Above it is a whole-chip count that wraps every 1.5 seconds, which is 15,345,000 chips. At the top is an epoch count of 1.5-second units that wraps once per week, which is 403,200 epochs. The bottom field has the same width as the code NCO phase adder. An overflow out of it is worth exactly one chip.

At each update strobe the block takes the NCO phase step per clock, which is a fixed bias plus a velocity correction from the loop filter. It multiplies that step by the number of NCO clocks in the elapsed interval and adds the product to the count. Every field wraps at its own modulus and carries upward.

Software can place an initial state through a synchronous load. A load with out-of-range fields is refused. A snapshot request returns a copy of the count pushed forward by a given skew advance, one cycle later. This lets channels that update on skewed schedules report on one common measurement tick. The live count is not touched by a snapshot.

Top module: `code_phase_acc`

## Requirements
- R1: During and after reset, the epoch, chip and fraction outputs are zero, and snapshot valid and load error are low.
- R2: The per-clock phase step is bias plus velocity, modulo 2^INC_W, with velocity in two's complement. On an update the advance is step × clock count. Its low FRAC_W bits are a chip fraction and its upper bits are whole chips. The new state is visible on the outputs in the cycle after the strobe.
- R3: The fraction field wraps modulo 2^FRAC_W. Each wrap adds one chip to the chip count.
- R4: The chip count stays below 15,345,000. When the sum reaches or exceeds 15,345,000, the chip count keeps the remainder and one epoch is carried up.
- R5: The epoch count stays below 403,200. It wraps from 403,199 to 0 when a carry arrives.
- R6: With neither update nor load asserted, the state does not change.
- R7: A load whose epoch and chip values are in range replaces all three fields in the next cycle. It takes priority over an update strobe in the same cycle.
- R8: A load with epoch ≥ 403,200 or chip ≥ 15,345,000 leaves the state unchanged and raises load error for exactly one cycle.
- R9: A snapshot request makes snapshot valid high for exactly the next cycle. The snapshot outputs then show the state as it stood in the request cycle, before any same-cycle update. The skew advance is added with the same carry rules, its low FRAC_W bits being fraction and the upper bits whole chips.
- R10: A snapshot request does not alter the live state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| upd_i | input | 1 | Update strobe |
| bias_i | input | INC_W | Fixed NCO phase step per clock |
| vel_i | input | INC_W | Loop-filter velocity correction, two's complement |
| nclk_i | input | CNT_W | NCO clocks in the elapsed interval |
| load_i | input | 1 | Load request |
| ld_epoch_i | input | EPOCH_W | Epoch value to load |
| ld_chip_i | input | CHIP_W | Chip value to load |
| ld_frac_i | input | FRAC_W | Fraction value to load |
| load_err_o | output | 1 | Load refused (out of range) |
| snap_req_i | input | 1 | Snapshot request |
| snap_adv_i | input | INC_W+CNT_W | Skew advance, fixed point in chips |
| snap_valid_o | output | 1 | Snapshot result valid |
| snap_epoch_o | output | EPOCH_W | Snapshot epoch |
| snap_chip_o | output | CHIP_W | Snapshot chip |
| snap_frac_o | output | FRAC_W | Snapshot fraction |
| epoch_o | output | EPOCH_W | Live epoch count |
| chip_o | output | CHIP_W | Live chip count |
| frac_o | output | FRAC_W | Live fraction |

## Verification
The bench builds the block with its default parameters. These are a 32-bit fraction, a 24-bit chip count with the real 15,345,000 modulus, a 19-bit epoch count with the 403,200 modulus, and a 16-bit clock count. This selects the compare-and-subtract wrap variant for both counters. Loads placed just below each modulus bring the fraction, chip and week wraps within a few updates. Maximum bias with maximum clock count produces the largest whole-chip advance, so the single-carry bound is exercised. A long run driven by a pseudo-random generator compares every update against an arithmetic model that uses division and remainder.

// File: rtl/cpa_pkg.sv
package cpa_pkg;

   // one 1.5 s epoch expressed in whole code chips
   localparam longint CPA_CHIP_MOD  = 64'd15345000;
   // one week expressed in 1.5 s epochs
   localparam longint CPA_EPOCH_MOD = 64'd403200;

   function automatic int cpa_max(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/cpa_adv_calc.sv
// Forms the per-interval phase advance: (bias + velocity) * clock count.
module cpa_adv_calc #(
   parameter int INC_W  = 32,
   parameter int CNT_W  = 16,
   parameter int FRAC_W = 32
) (
   input  logic [INC_W-1:0]                bias_i,
   input  logic [INC_W-1:0]                vel_i,
   input  logic [CNT_W-1:0]                nclk_i,
   output logic [INC_W+CNT_W-FRAC_W-1:0]   adv_whole_o,
   output logic [FRAC_W-1:0]               adv_frac_o
);
   localparam int PROD_W  = INC_W + CNT_W;
   localparam int WHOLE_W = PROD_W - FRAC_W;

   initial begin
      assert (PROD_W > FRAC_W)
         else $fatal(1, "cpa_adv_calc: product must be wider than the fraction");
   end

   logic [INC_W-1:0]  step;
   logic [PROD_W-1:0] prod;

   // velocity is two's complement; the sum wraps at the step width
   assign step = bias_i + vel_i;
   assign prod = PROD_W'(step) * PROD_W'(nclk_i);

   assign adv_frac_o  = prod[FRAC_W-1:0];
   assign adv_whole_o = WHOLE_W'(prod >> FRAC_W);

endmodule

// File: rtl/cpa_carry_chain.sv
// Adds a fixed-point advance to a (epoch, chip, fraction) count with
// modulo wrap and carry at each level. Purely combinational.
module cpa_carry_chain
   import cpa_pkg::*;
#(
   parameter int     FRAC_W    = 32,
   parameter int     CHIP_W    = 24,
   parameter int     EPOCH_W   = 19,
   parameter int     WHOLE_W   = 16,
   parameter longint CHIP_MOD  = CPA_CHIP_MOD,
   parameter longint EPOCH_MOD = CPA_EPOCH_MOD
) (
   input  logic [EPOCH_W-1:0] epoch_i,
   input  logic [CHIP_W-1:0]  chip_i,
   input  logic [FRAC_W-1:0]  frac_i,
   input  logic [WHOLE_W-1:0] adv_whole_i,
   input  logic [FRAC_W-1:0]  adv_frac_i,
   output logic [EPOCH_W-1:0] epoch_o,
   output logic [CHIP_W-1:0]  chip_o,
   output logic [FRAC_W-1:0]  frac_o
);
   localparam int XS_W = cpa_max(CHIP_W, WHOLE_W) + 2;
   localparam int ZS_W = EPOCH_W + 1;

   logic [FRAC_W:0]   frac_sum;
   logic [XS_W-1:0]   chip_sum;
   logic              chip_carry;
   logic [ZS_W-1:0]   epoch_sum;
   logic [ZS_W-1:0]   epoch_wrap;

   // fraction level: natural binary wrap, overflow is one chip
   assign frac_sum = {1'b0, frac_i} + {1'b0, adv_frac_i};
   assign frac_o   = frac_sum[FRAC_W-1:0];

   assign chip_sum = XS_W'(chip_i) + XS_W'(adv_whole_i) + XS_W'(frac_sum[FRAC_W]);

   // chip level: the modulus picks the wrap circuit
   generate
      if ((longint'(1) << CHIP_W) == CHIP_MOD) begin : g_chip_pow2
         assign chip_carry = |chip_sum[XS_W-1:CHIP_W];
         assign chip_o     = chip_sum[CHIP_W-1:0];
      end else begin : g_chip_cmp
         logic [XS_W-1:0] chip_wrap;
         assign chip_carry = (chip_sum >= XS_W'(CHIP_MOD));
         assign chip_wrap  = chip_carry ? (chip_sum - XS_W'(CHIP_MOD)) : chip_sum;
         assign chip_o     = CHIP_W'(chip_wrap);
      end
   endgenerate

   // epoch level: at most one carry arrives per addition
   assign epoch_sum  = {1'b0, epoch_i} + ZS_W'(chip_carry);
   generate
      if ((longint'(1) << EPOCH_W) == EPOCH_MOD) begin : g_epoch_pow2
         assign epoch_wrap = {1'b0, epoch_sum[EPOCH_W-1:0]};
      end else begin : g_epoch_cmp
         assign epoch_wrap = (epoch_sum >= ZS_W'(EPOCH_MOD)) ?
                             (epoch_sum - ZS_W'(EPOCH_MOD)) : epoch_sum;
      end
   endgenerate
   assign epoch_o = EPOCH_W'(epoch_wrap);

endmodule

// File: rtl/code_phase_acc.sv
// Code phase time count for one tracking channel: epoch / chip / fraction.
module code_phase_acc
   import cpa_pkg::*;
#(
   parameter int     FRAC_W    = 32,
   parameter int     CHIP_W    = 24,
   parameter int     EPOCH_W   = 19,
   parameter int     INC_W     = 32,
   parameter int     CNT_W     = 16,
   parameter longint CHIP_MOD  = CPA_CHIP_MOD,
   parameter longint EPOCH_MOD = CPA_EPOCH_MOD
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     upd_i,
   input  logic [INC_W-1:0]         bias_i,
   input  logic [INC_W-1:0]         vel_i,
   input  logic [CNT_W-1:0]         nclk_i,
   input  logic                     load_i,
   input  logic [EPOCH_W-1:0]       ld_epoch_i,
   input  logic [CHIP_W-1:0]        ld_chip_i,
   input  logic [FRAC_W-1:0]        ld_frac_i,
   output logic                     load_err_o,
   input  logic                     snap_req_i,
   input  logic [INC_W+CNT_W-1:0]   snap_adv_i,
   output logic                     snap_valid_o,
   output logic [EPOCH_W-1:0]       snap_epoch_o,
   output logic [CHIP_W-1:0]        snap_chip_o,
   output logic [FRAC_W-1:0]        snap_frac_o,
   output logic [EPOCH_W-1:0]       epoch_o,
   output logic [CHIP_W-1:0]        chip_o,
   output logic [FRAC_W-1:0]        frac_o
);
   localparam int ADV_W   = INC_W + CNT_W;
   localparam int WHOLE_W = ADV_W - FRAC_W;

   // elaboration-time parameter checks
   initial begin
      assert (CHIP_MOD <= (longint'(1) << CHIP_W))
         else $fatal(1, "code_phase_acc: CHIP_MOD does not fit CHIP_W");
      assert (EPOCH_MOD <= (longint'(1) << EPOCH_W))
         else $fatal(1, "code_phase_acc: EPOCH_MOD does not fit EPOCH_W");
      // largest whole-chip advance must stay below one chip wrap
      assert ((longint'(1) << WHOLE_W) <= CHIP_MOD)
         else $fatal(1, "code_phase_acc: advance may exceed one chip wrap");
      assert (WHOLE_W > 0)
         else $fatal(1, "code_phase_acc: no whole-chip bits in the advance");
   end

   // live state
   logic [EPOCH_W-1:0] epoch_q;
   logic [CHIP_W-1:0]  chip_q;
   logic [FRAC_W-1:0]  frac_q;

   // update advance
   logic [WHOLE_W-1:0] adv_whole;
   logic [FRAC_W-1:0]  adv_frac;

   cpa_adv_calc #(
      .INC_W  (INC_W),
      .CNT_W  (CNT_W),
      .FRAC_W (FRAC_W)
   ) u_adv (
      .bias_i      (bias_i),
      .vel_i       (vel_i),
      .nclk_i      (nclk_i),
      .adv_whole_o (adv_whole),
      .adv_frac_o  (adv_frac)
   );

   // next state for the live count
   logic [EPOCH_W-1:0] upd_epoch;
   logic [CHIP_W-1:0]  upd_chip;
   logic [FRAC_W-1:0]  upd_frac;

   cpa_carry_chain #(
      .FRAC_W    (FRAC_W),
      .CHIP_W    (CHIP_W),
      .EPOCH_W   (EPOCH_W),
      .WHOLE_W   (WHOLE_W),
      .CHIP_MOD  (CHIP_MOD),
      .EPOCH_MOD (EPOCH_MOD)
   ) u_live_chain (
      .epoch_i     (epoch_q),
      .chip_i      (chip_q),
      .frac_i      (frac_q),
      .adv_whole_i (adv_whole),
      .adv_frac_i  (adv_frac),
      .epoch_o     (upd_epoch),
      .chip_o      (upd_chip),
      .frac_o      (upd_frac)
   );

   // snapshot copy pushed forward by the skew advance
   logic [EPOCH_W-1:0] skw_epoch;
   logic [CHIP_W-1:0]  skw_chip;
   logic [FRAC_W-1:0]  skw_frac;

   cpa_carry_chain #(
      .FRAC_W    (FRAC_W),
      .CHIP_W    (CHIP_W),
      .EPOCH_W   (EPOCH_W),
      .WHOLE_W   (WHOLE_W),
      .CHIP_MOD  (CHIP_MOD),
      .EPOCH_MOD (EPOCH_MOD)
   ) u_snap_chain (
      .epoch_i     (epoch_q),
      .chip_i      (chip_q),
      .frac_i      (frac_q),
      .adv_whole_i (snap_adv_i[ADV_W-1:FRAC_W]),
      .adv_frac_i  (snap_adv_i[FRAC_W-1:0]),
      .epoch_o     (skw_epoch),
      .chip_o      (skw_chip),
      .frac_o      (skw_frac)
   );

   // load range check
   logic ld_ok;
   assign ld_ok = ({1'b0, ld_epoch_i} < (EPOCH_W+1)'(EPOCH_MOD)) &&
                  ({1'b0, ld_chip_i}  < (CHIP_W+1)'(CHIP_MOD));

   logic load_err_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         epoch_q    <= '0;
         chip_q     <= '0;
         frac_q     <= '0;
         load_err_q <= 1'b0;
      end else begin
         load_err_q <= 1'b0;
         if (load_i) begin
            if (ld_ok) begin
               epoch_q <= ld_epoch_i;
               chip_q  <= ld_chip_i;
               frac_q  <= ld_frac_i;
            end else begin
               load_err_q <= 1'b1;
            end
         end else if (upd_i) begin
            epoch_q <= upd_epoch;
            chip_q  <= upd_chip;
            frac_q  <= upd_frac;
         end
      end
   end

   logic               snap_valid_q;
   logic [EPOCH_W-1:0] snap_epoch_q;
   logic [CHIP_W-1:0]  snap_chip_q;
   logic [FRAC_W-1:0]  snap_frac_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         snap_valid_q <= 1'b0;
         snap_epoch_q <= '0;
         snap_chip_q  <= '0;
         snap_frac_q  <= '0;
      end else begin
         snap_valid_q <= snap_req_i;
         if (snap_req_i) begin
            snap_epoch_q <= skw_epoch;
            snap_chip_q  <= skw_chip;
            snap_frac_q  <= skw_frac;
         end
      end
   end

   assign epoch_o      = epoch_q;
   assign chip_o       = chip_q;
   assign frac_o       = frac_q;
   assign load_err_o   = load_err_q;
   assign snap_valid_o = snap_valid_q;
   assign snap_epoch_o = snap_epoch_q;
   assign snap_chip_o  = snap_chip_q;
   assign snap_frac_o  = snap_frac_q;

   // ---------------------------------------------------------------
   // assertions
   // ---------------------------------------------------------------
   assert_frac_advance_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_i && !load_i) |=> (frac_o == FRAC_W'($past(frac_o) + $past(adv_frac))));

   assert_chip_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ({1'b0, chip_o} < (CHIP_W+1)'(CHIP_MOD)));

   assert_epoch_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ({1'b0, epoch_o} < (EPOCH_W+1)'(EPOCH_MOD)));

   assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!upd_i && !load_i) |=> ($stable(epoch_o) && $stable(chip_o) && $stable(frac_o)));

   assert_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (load_i && ld_ok) |=> (epoch_o == $past(ld_epoch_i) && chip_o == $past(ld_chip_i)
                             && frac_o == $past(ld_frac_i)));

   assert_load_reject_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (load_i && !ld_ok) |=> (load_err_o && $stable(epoch_o) && $stable(chip_o)
                              && $stable(frac_o)));

   assert_no_spurious_err_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !(load_i && !ld_ok) |=> !load_err_o);

   assert_snap_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
      snap_req_i |=> snap_valid_o);

   assert_snap_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !snap_req_i |=> !snap_valid_o);

endmodule

// File: tb/sim_code_phase_acc.sv
`timescale 1ns/1ps
module sim_code_phase_acc;

   localparam longint CM   = 64'd15345000;
   localparam longint EM   = 64'd403200;
   localparam longint MASK = 64'hFFFF_FFFF;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        upd_i = 1'b0;
   logic [31:0] bias_i = '0;
   logic [31:0] vel_i = '0;
   logic [15:0] nclk_i = '0;
   logic        load_i = 1'b0;
   logic [18:0] ld_epoch_i = '0;
   logic [23:0] ld_chip_i = '0;
   logic [31:0] ld_frac_i = '0;
   logic        load_err_o;
   logic        snap_req_i = 1'b0;
   logic [47:0] snap_adv_i = '0;
   logic        snap_valid_o;
   logic [18:0] snap_epoch_o;
   logic [23:0] snap_chip_o;
   logic [31:0] snap_frac_o;
   logic [18:0] epoch_o;
   logic [23:0] chip_o;
   logic [31:0] frac_o;

   int n_checks = 0;
   int n_errors = 0;

   // model state
   longint mz = 0, mx = 0, mp = 0;

   always #4 clk = ~clk;   // 125 MHz

   code_phase_acc u0 (
      .clk(clk), .rst_n(rst_n), .upd_i(upd_i), .bias_i(bias_i), .vel_i(vel_i),
      .nclk_i(nclk_i), .load_i(load_i), .ld_epoch_i(ld_epoch_i),
      .ld_chip_i(ld_chip_i), .ld_frac_i(ld_frac_i), .load_err_o(load_err_o),
      .snap_req_i(snap_req_i), .snap_adv_i(snap_adv_i),
      .snap_valid_o(snap_valid_o), .snap_epoch_o(snap_epoch_o),
      .snap_chip_o(snap_chip_o), .snap_frac_o(snap_frac_o),
      .epoch_o(epoch_o), .chip_o(chip_o), .frac_o(frac_o)
   );

   task automatic chk(input string req, input longint act, input longint exp);
      n_checks++;
      if (act != exp) begin
         n_errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // arithmetic model: total chips split by division and remainder
   task automatic madd(inout longint z, inout longint x, inout longint p,
                       input longint whole, input longint frac);
      longint ps, xs;
      ps = p + frac;
      xs = x + whole + (ps >> 32);
      p  = ps & MASK;
      z  = (z + xs / CM) % EM;
      x  = xs % CM;
   endtask

   task automatic chk_state(input string req);
      chk({req, " epoch"}, longint'(epoch_o), mz);
      chk({req, " chip"},  longint'(chip_o),  mx);
      chk({req, " frac"},  longint'(frac_o),  mp);
   endtask

   task automatic do_load(input longint z, input longint x, input longint p);
      @(negedge clk);
      load_i = 1'b1; ld_epoch_i = 19'(z); ld_chip_i = 24'(x); ld_frac_i = 32'(p);
      @(negedge clk);
      load_i = 1'b0;
      mz = z; mx = x; mp = p;
   endtask

   task automatic do_update(input string req, input longint bias, input longint vel,
                            input longint n);
      longint step, adv;
      @(negedge clk);
      upd_i = 1'b1; bias_i = 32'(bias); vel_i = 32'(vel); nclk_i = 16'(n);
      @(negedge clk);
      upd_i = 1'b0;
      step = (bias + vel) & MASK;
      adv  = step * n;
      madd(mz, mx, mp, adv >> 32, adv & MASK);
      chk_state(req);
   endtask

   task automatic t_reset();
      chk("R1 epoch", longint'(epoch_o), 0);
      chk("R1 chip", longint'(chip_o), 0);
      chk("R1 frac", longint'(frac_o), 0);
      chk("R1 snap_valid", longint'(snap_valid_o), 0);
      chk("R1 load_err", longint'(load_err_o), 0);
   endtask

   task automatic t_basic();
      // 0.5 chip per clock, 3 clocks: 1.5 chips
      do_update("R2 basic", 64'h8000_0000, 0, 3);
      chk("R2 chip literal", longint'(chip_o), 1);
      chk("R2 frac literal", longint'(frac_o), 64'h8000_0000);
      // second step wraps the fraction into a chip
      do_update("R3 frac carry", 64'h8000_0000, 0, 3);
      chk("R3 chip literal", longint'(chip_o), 3);
      chk("R3 frac literal", longint'(frac_o), 0);
   endtask

   task automatic t_negvel();
      // velocity -0x1000_0000 against bias 0x4000_0000
      do_update("R2 negative velocity", 64'h4000_0000, 64'hF000_0000, 1000);
      do_update("R2 positive velocity", 64'h4000_0000, 64'h0123_4567, 777);
   endtask

   task automatic t_hold();
      @(negedge clk);
      bias_i = 32'hFFFF_FFFF; nclk_i = 16'hFFFF;   // upd_i stays low
      repeat (4) @(negedge clk);
      chk_state("R6 hold");
   endtask

   task automatic t_chip_wrap();
      do_load(5, CM - 2, 64'hC000_0000);
      chk_state("R7 load");
      do_update("R4 chip wrap", 64'h8000_0000, 0, 3);
      chk("R4 chip to zero", longint'(chip_o), 0);
      chk("R4 epoch carry", longint'(epoch_o), 6);
      chk("R3 frac after wrap", longint'(frac_o), 64'h4000_0000);
   endtask

   task automatic t_epoch_wrap();
      do_load(EM - 1, CM - 1, MASK);
      do_update("R5 week wrap", 1, 0, 1);
      chk("R5 epoch zero", longint'(epoch_o), 0);
      chk("R5 chip zero", longint'(chip_o), 0);
      chk("R5 frac zero", longint'(frac_o), 0);
   endtask

   task automatic t_load_prio();
      @(negedge clk);
      load_i = 1'b1; ld_epoch_i = 19'd1234; ld_chip_i = 24'd99; ld_frac_i = 32'd7;
      upd_i = 1'b1; bias_i = 32'h1000_0000; vel_i = '0; nclk_i = 16'd50;
      @(negedge clk);
      load_i = 1'b0; upd_i = 1'b0;
      mz = 1234; mx = 99; mp = 7;
      chk_state("R7 load over update");
   endtask

   task automatic t_load_bad();
      @(negedge clk);
      load_i = 1'b1; ld_epoch_i = 19'(EM); ld_chip_i = 24'd5; ld_frac_i = 32'd5;
      @(negedge clk);
      load_i = 1'b0;
      chk("R8 err epoch", longint'(load_err_o), 1);
      chk_state("R8 state after bad epoch");
      @(negedge clk);
      chk("R8 err one cycle", longint'(load_err_o), 0);
      load_i = 1'b1; ld_epoch_i = 19'd3; ld_chip_i = 24'(CM); ld_frac_i = 32'd5;
      upd_i = 1'b1; bias_i = 32'h1000_0000; nclk_i = 16'd4;
      @(negedge clk);
      load_i = 1'b0; upd_i = 1'b0;
      chk("R8 err chip", longint'(load_err_o), 1);
      chk_state("R8 state after bad chip");
   endtask

   task automatic t_snap();
      longint ez, ex, ep;
      do_load(10, CM - 1, 64'h8000_0000);
      @(negedge clk);
      snap_req_i = 1'b1;
      snap_adv_i = {16'd2, 32'h8000_0000};
      @(negedge clk);
      snap_req_i = 1'b0;
      chk("R9 valid", longint'(snap_valid_o), 1);
      chk("R9 snap epoch", longint'(snap_epoch_o), 11);
      chk("R9 snap chip", longint'(snap_chip_o), 2);
      chk("R9 snap frac", longint'(snap_frac_o), 0);
      chk_state("R10 live unchanged");
      @(negedge clk);
      chk("R9 valid one cycle", longint'(snap_valid_o), 0);
      // snapshot in the same cycle as an update sees the pre-update count
      ez = mz; ex = mx; ep = mp;
      madd(ez, ex, ep, 300, 64'h1234_5678);
      @(negedge clk);
      snap_req_i = 1'b1; snap_adv_i = {16'd300, 32'h1234_5678};
      upd_i = 1'b1; bias_i = 32'h2000_0000; vel_i = '0; nclk_i = 16'd9;
      @(negedge clk);
      snap_req_i = 1'b0; upd_i = 1'b0;
      madd(mz, mx, mp, 1, 64'h2000_0000);
      chk("R9 pre-update epoch", longint'(snap_epoch_o), ez);
      chk("R9 pre-update chip", longint'(snap_chip_o), ex);
      chk("R9 pre-update frac", longint'(snap_frac_o), ep);
      chk_state("R10 update alongside snapshot");
   endtask

   task automatic t_stress();
      longint lcg = 64'h1234_5678;
      do_load(EM - 3, CM - 70000, 0);
      do_update("R4 max advance", MASK, 0, 64'hFFFF);
      for (int i = 0; i < 300; i++) begin
         lcg = (lcg * 1103515245 + 12345) & 64'h7FFF_FFFF;
         do_update("R2 sweep", (lcg << 1) & MASK, (lcg >> 3) & MASK, (lcg >> 7) & 64'hFFFF);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_basic();
      t_negvel();
      t_hold();
      t_chip_wrap();
      t_epoch_wrap();
      t_load_prio();
      t_load_bad();
      t_snap();
      t_stress();
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

endmodule